// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches a configurable set of asynchronous event lines and turns selected transitions on them into interrupts. Every line is brought into the clock domain by a short flop chain. The block then compares the settled value with its value one cycle earlier to find rising and falling transitions. For each line, software chooses whether rising transitions, falling transitions, both or neither count as a trigger.

A qualifying transition does two things. It latches a sticky flag for that line, which software later clears by writing ones to it. If the line's interrupt enable is set, it also sends a single-cycle pulse on that line's interrupt output. A steady level never produces a second pulse.

Software reaches six 32-bit registers through a small synchronous register port inside a 1 KiB window. Read data and an error flag appear one cycle after the access.

Top module: `exti_ctrl`

## Requirements
- R1: After reset every register reads as zero, no interrupt output is active and the error flag is low.
- R2: A 0-to-1 transition on a line whose bit is set in the rise-select register (offset 0x08) sets that line's bit in the pending register (offset 0x14).
- R3: A 1-to-0 transition on a line whose bit is set in the fall-select register (offset 0x0C) sets that line's pending bit.
- R4: A transition of a kind whose select bit is 0 for that line leaves the pending bit at 0 and produces no interrupt pulse.
- R5: A write to the pending register clears each pending bit whose write-data bit is 1 and leaves the others unchanged.
- R6: A qualifying transition with the line's interrupt-enable bit (offset 0x00) at 1 raises that line's irq output for exactly one cycle, in the third clock edge after the input changes. A steady input level produces no further pulse.
- R7: With the line's interrupt-enable bit at 0, a qualifying transition produces no pulse but still sets the pending bit.
- R8: The interrupt-enable (0x00), event-enable (0x04), rise-select (0x08), fall-select (0x0C) and software-event (0x10) registers store all 32 written bits and read them back unchanged. Read data is valid in the cycle after the read request.
- R9: An access to any other offset, including an offset with a nonzero low two bits, returns zero read data and raises the error flag in the following cycle. A write to such an offset changes no register.
- R10: When a transition sets a pending bit at the same clock edge in which software writes 1 to clear that bit, the bit ends up set.
- R11: Pending bits at positions NUM_LINES and above always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | NUM_LINES | Asynchronous event lines |
| bus_valid_i | input | 1 | Register access request, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset in the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| bus_err_o | output | 1 | Unmapped-offset flag, valid the cycle after an access |
| irq_o | output | NUM_LINES | Per-line single-cycle interrupt pulses |

## Verification
An input change goes through two synchroniser edges and then one register edge. The bench therefore samples irq on the falling edge after each of the first four rising edges following the change. It expects a pulse only after the third, and it catches both late and repeated pulses. Register results are sampled on the falling edge that follows the single rising edge which registers the access, so read data and the error flag are checked exactly one cycle after the request. To test the same-edge clear, the bench drives a pending-clear write into the third edge after a line change, which is the edge that sets the bit.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int unsigned REG_W = 32;

    // Values 0..5 are the word index of the register inside the window.
    typedef enum logic [2:0] {
        SEL_IEN   = 3'd0,
        SEL_EEN   = 3'd1,
        SEL_RISE  = 3'd2,
        SEL_FALL  = 3'd3,
        SEL_SWEV  = 3'd4,
        SEL_PEND  = 3'd5,
        SEL_NONE  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/exti_line_sync.sv
module exti_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], line_i};
        st_d.prev  = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o =  st_q.chain[TOP] & ~st_q.prev;
    assign fall_o = ~st_q.chain[TOP] &  st_q.prev;

    // A rising indication requires the raw input to have been high STAGES edges ago (R2).
    p_rise_from_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(line_i, 2));

    // A falling indication requires the raw input to have been low (R3).
    p_fall_from_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(line_i, 2));

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned ADDR_W    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise_i,
    input  logic [NUM_LINES-1:0] fall_i,
    input  logic                 bus_valid_i,
    input  logic                 bus_write_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [REG_W-1:0]     bus_wdata_i,
    output logic [REG_W-1:0]     bus_rdata_o,
    output logic                 bus_err_o,
    output logic [NUM_LINES-1:0] irq_o
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(5);

    typedef struct packed {
        logic [REG_W-1:0]     ien;
        logic [REG_W-1:0]     een;
        logic [REG_W-1:0]     rsel;
        logic [REG_W-1:0]     fsel;
        logic [REG_W-1:0]     swev;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] irq;
        logic [REG_W-1:0]     rdata;
        logic                 err;
    } regs_st_t;

    regs_st_t st_d, st_q;

    reg_sel_e             sel;
    logic [WORD_W-1:0]    word;
    logic                 misalign;
    logic                 wr_en;
    logic                 rd_en;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] clr;

    always_comb begin
        word     = bus_addr_i[ADDR_W-1:2];
        misalign = |bus_addr_i[1:0];
        if (misalign || (word > LAST_WORD)) sel = SEL_NONE;
        else                                sel = reg_sel_e'(word[2:0]);

        wr_en = bus_valid_i &  bus_write_i;
        rd_en = bus_valid_i & ~bus_write_i;
        hit   = (rise_i & st_q.rsel[NUM_LINES-1:0]) | (fall_i & st_q.fsel[NUM_LINES-1:0]);
        clr   = '0;

        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = bus_valid_i & (sel == SEL_NONE);

        if (wr_en) begin
            case (sel)
                SEL_IEN:  st_d.ien  = bus_wdata_i;
                SEL_EEN:  st_d.een  = bus_wdata_i;
                SEL_RISE: st_d.rsel = bus_wdata_i;
                SEL_FALL: st_d.fsel = bus_wdata_i;
                SEL_SWEV: st_d.swev = bus_wdata_i;
                SEL_PEND: clr       = bus_wdata_i[NUM_LINES-1:0];
                default:  ;
            endcase
        end

        // New transitions take priority over a same-edge clear.
        st_d.pend = (st_q.pend & ~clr) | hit;
        st_d.irq  = hit & st_q.ien[NUM_LINES-1:0];

        if (rd_en) begin
            case (sel)
                SEL_IEN:  st_d.rdata = st_q.ien;
                SEL_EEN:  st_d.rdata = st_q.een;
                SEL_RISE: st_d.rdata = st_q.rsel;
                SEL_FALL: st_d.rdata = st_q.fsel;
                SEL_SWEV: st_d.rdata = st_q.swev;
                SEL_PEND: st_d.rdata[NUM_LINES-1:0] = st_q.pend;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;
    assign bus_err_o   = st_q.err;
    assign irq_o       = st_q.irq;

    p_rise_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        |(rise_i & st_q.rsel[NUM_LINES-1:0]) |=>
        ((st_q.pend & $past(rise_i & st_q.rsel[NUM_LINES-1:0])) ==
         $past(rise_i & st_q.rsel[NUM_LINES-1:0])));

    p_fall_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        |(fall_i & st_q.fsel[NUM_LINES-1:0]) |=>
        ((st_q.pend & $past(fall_i & st_q.fsel[NUM_LINES-1:0])) ==
         $past(fall_i & st_q.fsel[NUM_LINES-1:0])));

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PEND && !(|rise_i) && !(|fall_i)) |=>
        (st_q.pend == ($past(st_q.pend) & ~$past(bus_wdata_i[NUM_LINES-1:0]))));

    p_irq_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~$past(rise_i | fall_i)) == '0);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~$past(st_q.ien[NUM_LINES-1:0])) == '0);

    p_unmapped_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && sel == SEL_NONE) |=> (bus_err_o && bus_rdata_o == '0));

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 16,  // 1..32
    parameter int unsigned ADDR_W      = 10,  // 1 KiB register window
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 bus_valid_i,
    input  logic                 bus_write_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [REG_W-1:0]     bus_wdata_i,
    output logic [REG_W-1:0]     bus_rdata_o,
    output logic                 bus_err_o,
    output logic [NUM_LINES-1:0] irq_o
);

    logic [NUM_LINES-1:0] rise_vec;
    logic [NUM_LINES-1:0] fall_vec;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        exti_line_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_i[g]),
            .rise_o (rise_vec[g]),
            .fall_o (fall_vec[g])
        );
    end

    exti_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise_vec),
        .fall_i      (fall_vec),
        .bus_valid_i (bus_valid_i),
        .bus_write_i (bus_write_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .bus_err_o   (bus_err_o),
        .irq_o       (irq_o)
    );

endmodule

// File: tb/exti_ctrl_tb_top.sv
`timescale 1ns/1ps
module exti_ctrl_tb_top;

    localparam int unsigned NL = 4;
    localparam int unsigned AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line = '0;
    logic          bvalid = 1'b0;
    logic          bwrite = 1'b0;
    logic [AW-1:0] baddr = '0;
    logic [31:0]   bwdata = '0;
    logic [31:0]   brdata;
    logic          berr;
    logic [NL-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exti_ctrl #(.NUM_LINES(NL), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line),
        .bus_valid_i(bvalid), .bus_write_i(bwrite), .bus_addr_i(baddr),
        .bus_wdata_i(bwdata), .bus_rdata_o(brdata), .bus_err_o(berr), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bvalid = 1'b1; bwrite = 1'b1; baddr = a; bwdata = d;
        @(negedge clk);
        bvalid = 1'b0; bwrite = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic e);
        bvalid = 1'b1; bwrite = 1'b0; baddr = a;
        @(negedge clk);
        d = brdata; e = berr;
        bvalid = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        logic e;
        rd(a, d, e);
        chk(d == exp, req, d, exp);
        chk(e == 1'b0, {req, " err"}, {31'd0, e}, 32'd0);
    endtask

    // Drive one line and check the irq vector after each of the next four edges.
    task automatic drive_line(input int idx, input logic v, input logic [NL-1:0] exp_irq, input string req);
        line[idx] = v;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 3) chk(irq == exp_irq, req, {28'd0, irq}, {28'd0, exp_irq});
            else        chk(irq == '0, {req, " no extra pulse"}, {28'd0, irq}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h1234_8001; pats[3] = 32'h0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(irq == '0, "R1 irq", {28'd0, irq}, 32'd0);
        chk(berr == 1'b0, "R1 err", {31'd0, berr}, 32'd0);
        for (int r = 0; r < 6; r++) rd_chk(AW'(r * 4), 32'd0, "R1 reset value");

        // R8: plain storage registers
        for (int r = 0; r < 5; r++)
            for (int p = 0; p < 4; p++) begin
                wr(AW'(r * 4), pats[p] ^ (32'h1 << r));
                rd_chk(AW'(r * 4), pats[p] ^ (32'h1 << r), "R8 readback");
            end
        for (int r = 0; r < 5; r++) wr(AW'(r * 4), 32'd0);

        // R9: unmapped offsets
        wr(10'h018, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(berr == 1'b0, "R9 err pulse one cycle", {31'd0, berr}, 32'd0);
        wr(10'h3FC, 32'hFFFF_FFFF);
        wr(10'h002, 32'hFFFF_FFFF);
        for (int r = 0; r < 6; r++) rd_chk(AW'(r * 4), 32'd0, "R9 write ignored");
        rd(10'h018, d, e); chk(d == 0 && e, "R9 read 0x18", d, 32'd0);
        rd(10'h3FC, d, e); chk(d == 0 && e, "R9 read 0x3FC", d, 32'd0);
        rd(10'h006, d, e); chk(d == 0 && e, "R9 read misaligned", d, 32'd0);

        // Sweep: every line, every trigger selection, both enable values
        for (int i = 0; i < NL; i++)
            for (int cfg = 0; cfg < 4; cfg++)
                for (int m = 0; m < 2; m++) begin
                    logic rt, ft;
                    rt = cfg[0]; ft = cfg[1];
                    wr(10'h008, 32'(rt) << i);
                    wr(10'h00C, 32'(ft) << i);
                    wr(10'h000, 32'(m) << i);
                    wr(10'h014, 32'hFFFF_FFFF);
                    drive_line(i, 1'b1, NL'(rt & m[0]) << i,
                               rt ? (m ? "R6 rise pulse" : "R7 masked rise") : "R4 rise not selected");
                    rd_chk(10'h014, 32'(rt) << i, rt ? "R2 rise pending" : "R4 rise pending");
                    wr(10'h014, 32'hFFFF_FFFF);
                    rd_chk(10'h014, 32'd0, "R5 clear all");
                    drive_line(i, 1'b0, NL'(ft & m[0]) << i,
                               ft ? (m ? "R6 fall pulse" : "R7 masked fall") : "R4 fall not selected");
                    rd_chk(10'h014, 32'(ft) << i, ft ? "R3 fall pending" : "R4 fall pending");
                end

        // R5: partial clear leaves other bits
        wr(10'h008, 32'hF); wr(10'h00C, 32'h0); wr(10'h000, 32'h0);
        wr(10'h014, 32'hFFFF_FFFF);
        line = 4'hF;
        repeat (4) @(negedge clk);
        rd_chk(10'h014, 32'hF, "R11 upper pending bits zero");
        wr(10'h014, 32'h5);
        rd_chk(10'h014, 32'hA, "R5 partial clear");
        wr(10'h014, 32'h0);
        rd_chk(10'h014, 32'hA, "R5 zero write keeps bits");
        line = 4'h0;
        repeat (4) @(negedge clk);
        wr(10'h014, 32'hFFFF_FFFF);

        // R10: set wins over clear at the same edge
        wr(10'h008, 32'h3);
        line[1] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk(10'h014, 32'h2, "R10 setup");
        line[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(10'h014, 32'h3);
        rd_chk(10'h014, 32'h1, "R10 edge wins over clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule